// File: doc/BRIEF.md
# Byte-Lane Asynchronous SRAM Controller

This block is a clocked front end for an external asynchronous static RAM of 256K words by 16 bits. The RAM has active-low chip, write and output enables and one active-low enable per byte lane. A host hands the controller one access at a time: an 18-bit word address, a write flag, 16 bits of write data and a 2-bit byte mask. The controller latches the request and walks the RAM strobes through a fixed sequence. Each phase is sized in clock cycles from the RAM's nanosecond minimums. It then reports completion with a one-cycle done pulse, which carries the read data for reads.

The request side is valid/ready. The host raises `req_valid` with stable fields and holds them until it sees `req_ready` high at a rising clock edge. That edge accepts the request. `req_ready` is high only while the controller is idle, so it is the only back-pressure. The response side has no back-pressure: `rsp_valid` is a single-cycle pulse that the host must take when it comes. The RAM data bus is split into a driven value, an output enable for that value, and the value read back from the pads.

Phase lengths come from the speed grade (`SLOW_GRADE`: 0 for the 55 ns grade, 1 for the 70 ns grade) and the clock period `CLK_PS`. Each length is a nanosecond minimum divided by the period and rounded up. With the defaults (fast grade, 10 ns clock) the values are:

| Phase | Formula | Default |
|---|---|---|
| read wait W | max(ceil(address-to-data) - 1, ceil(output-enable-to-data)) | 5 |
| write pulse P | max(ceil(write pulse), ceil(max(chip-enable-to-end, data setup)) - 1) | 4 |
| write recovery Q | max(1, ceil(write cycle) - 1 - P) | 1 |
| turnaround T | max(1, ceil(bus release)) | 2 |

Top module: `bytelane_sram_ctrl`

## Requirements
- R1: `req_ready` is high only when no access is in progress. A request is accepted on a rising edge with `req_valid` and `req_ready` both high. `req_ready` is low in the cycle after acceptance and stays low until the access and its turnaround finish.
- R2: Byte mask bit 0 selects bits 7:0 and bit 1 selects bits 15:8. During an access `ram_be_n[i]` is the inverse of mask bit i, so a write changes only the selected lanes of the addressed word. `ram_we_n` is low only while `ram_ce_n` is low and `ram_oe_n` is high.
- R3: On a write, `ram_we_n` goes low one cycle after the address and data appear on the pins. It stays low for at least P cycles and rises at least one cycle before the address or data change, so data setup and hold are met at the edge that ends the write.
- R4: On a read, `ram_oe_n` is low with `ram_we_n` high for W cycles. The data is sampled on the edge that ends that window. Lanes whose mask bit is 0 return zero in `rsp_rdata`.
- R5: `rsp_valid` is high for exactly one cycle per access. It is high in the (W+2)th cycle after acceptance for a read and in the (P+Q+1)th cycle for a write, counting the first cycle after the accepting edge as cycle 1.
- R6: `ram_dq_oe` is high only during the write phases and is never high in a cycle where `ram_oe_n` is low.
- R7: After each access the controller idles the bus for T cycles. `req_ready` returns exactly T+1 cycles after the `rsp_valid` cycle, so the RAM has released the bus before the controller drives it again.
- R8: A request with mask 00 leaves both byte enables high. A write with mask 00 changes no stored data, and a read with mask 00 returns zero.
- R9: While reset is asserted: all RAM strobes are high (both byte enables included), `ram_dq_oe` is low, `rsp_valid` is low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle; request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Byte lanes to access (bit 0 = bits 7:0) |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_valid after a read |
| ram_addr | output | 18 | RAM address pins |
| ram_ce_n | output | 1 | RAM chip enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_be_n | output | 2 | RAM byte-lane enables, active low (bit 0 = bits 7:0) |
| ram_dq_out | output | 16 | Value driven onto the RAM data bus |
| ram_dq_oe | output | 1 | Controller drives the data bus |
| ram_dq_in | input | 16 | Value seen on the RAM data bus |

## Verification
The bench pairs the controller with a byte-lane memory model. The model returns filler bytes on disabled lanes and on lanes whose output enable has been low for too short a time. It also keeps driving for two cycles after output enable rises.

The bench then targets the corner cases:
- Partial writes followed by full and single-lane reads. A mask inverted or applied to the wrong lane would corrupt the neighbouring byte or leak filler into a masked-off lane.
- An empty mask. A controller that pulses a lane anyway would change stored data.
- Back-to-back requests. A shortened turnaround or wait phase would show up as bus contention in the model, a wrong latency, or unsettled read data.
- The timing of the write strobe against the address and data. A write enable that is early, short or late would break setup or hold as the model measures them.

// File: rtl/bls_pkg.sv
`timescale 1ns/1ps
package bls_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_SETUP,
    ST_RD_WAIT,
    ST_RD_CAP,
    ST_WR_SETUP,
    ST_WR_PULSE,
    ST_WR_REC,
    ST_TURN
  } bls_state_e;

  // nanoseconds to whole clock cycles, rounded up
  function automatic int cyc_ceil(input int t_ns, input int clk_ps);
    return (t_ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/bls_fsm.sv
`timescale 1ns/1ps
module bls_fsm
  import bls_pkg::*;
#(
  parameter int RD_WAIT_C  = 5,
  parameter int WR_PULSE_C = 4,
  parameter int WR_REC_C   = 1,
  parameter int TURN_C     = 2,
  parameter int CNT_W      = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       req_write,
  output logic       req_ready,
  output logic       accept,
  output logic       sample,
  output logic       rsp_valid,
  output bls_state_e state
);

  localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_WAIT_C - 1);
  localparam logic [CNT_W-1:0] LD_WP   = CNT_W'(WR_PULSE_C - 1);
  localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(WR_REC_C - 1);
  localparam logic [CNT_W-1:0] LD_TURN = CNT_W'(TURN_C - 1);

  bls_state_e       nxt;
  logic [CNT_W-1:0] cnt, cnt_nxt;
  logic             cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_comb begin
    nxt     = state;
    cnt_nxt = cnt_zero ? '0 : cnt - 1'b1;
    case (state)
      ST_IDLE:     if (req_valid) nxt = req_write ? ST_WR_SETUP : ST_RD_SETUP;
      ST_RD_SETUP: begin nxt = ST_RD_WAIT;  cnt_nxt = LD_RD;   end
      ST_RD_WAIT:  if (cnt_zero) nxt = ST_RD_CAP;
      ST_RD_CAP:   begin nxt = ST_TURN;     cnt_nxt = LD_TURN; end
      ST_WR_SETUP: begin nxt = ST_WR_PULSE; cnt_nxt = LD_WP;   end
      ST_WR_PULSE: if (cnt_zero) begin nxt = ST_WR_REC; cnt_nxt = LD_WR; end
      ST_WR_REC:   if (cnt_zero) begin nxt = ST_TURN; cnt_nxt = LD_TURN; end
      ST_TURN:     if (cnt_zero) nxt = ST_IDLE;
      default:     nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= nxt;
      cnt   <= cnt_nxt;
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign sample    = (state == ST_RD_WAIT) && cnt_zero;
  assign rsp_valid = (state == ST_RD_CAP) || ((state == ST_WR_REC) && cnt_zero);

  // R5: the read sample edge is followed by the done pulse
  assert_sample_then_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sample |=> rsp_valid);

endmodule

// File: rtl/bls_hold.sv
`timescale 1ns/1ps
module bls_hold #(
  parameter int ADDR_W = 18,
  parameter int DATA_W = 16,
  parameter int LANES  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              sample,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [LANES-1:0]  in_mask,
  input  logic [DATA_W-1:0] ram_dq_in,
  output logic [ADDR_W-1:0] h_addr,
  output logic [DATA_W-1:0] h_wdata,
  output logic [LANES-1:0]  h_mask,
  output logic [DATA_W-1:0] rdata
);

  localparam int LANE_W = DATA_W / LANES;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_addr  <= '0;
      h_wdata <= '0;
      h_mask  <= '0;
    end else if (accept) begin
      h_addr  <= in_addr;
      h_wdata <= in_wdata;
      h_mask  <= in_mask;
    end
  end

  logic [LANE_W-1:0] lane_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      lane_q[g] <= '0;
      else if (sample) lane_q[g] <= h_mask[g] ? ram_dq_in[g*LANE_W +: LANE_W] : '0;
    end
    assign rdata[g*LANE_W +: LANE_W] = lane_q[g];

    // R4: an unselected lane reads back as zero
    assert_lane_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sample && !h_mask[g]) |=> (rdata[g*LANE_W +: LANE_W] == '0));
  end

endmodule

// File: rtl/bls_pins.sv
`timescale 1ns/1ps
module bls_pins
  import bls_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int LANES      = 2,
  parameter int WR_PULSE_C = 4,
  parameter int TURN_C     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bls_state_e        state,
  input  logic [ADDR_W-1:0] h_addr,
  input  logic [DATA_W-1:0] h_wdata,
  input  logic [LANES-1:0]  h_mask,
  output logic [ADDR_W-1:0] ram_addr,
  output logic              ram_ce_n,
  output logic              ram_we_n,
  output logic              ram_oe_n,
  output logic [LANES-1:0]  ram_be_n,
  output logic [DATA_W-1:0] ram_dq_out,
  output logic              ram_dq_oe
);

  logic in_access, in_write;

  assign in_write  = state inside {ST_WR_SETUP, ST_WR_PULSE, ST_WR_REC};
  assign in_access = in_write || (state inside {ST_RD_SETUP, ST_RD_WAIT, ST_RD_CAP});

  assign ram_addr   = h_addr;
  assign ram_ce_n   = !in_access;
  assign ram_be_n   = in_access ? ~h_mask : '1;
  assign ram_oe_n   = (state != ST_RD_WAIT);
  assign ram_we_n   = (state != ST_WR_PULSE);
  assign ram_dq_out = h_wdata;
  assign ram_dq_oe  = in_write;

  // observation counters for the timing checks below
  localparam int WEC_W = $clog2(WR_PULSE_C + 1);
  localparam int TRC_W = $clog2(TURN_C + 1);

  logic [WEC_W-1:0] we_low_cnt;
  logic [TRC_W-1:0] since_oe;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
      since_oe   <= TRC_W'(TURN_C);
    end else begin
      if (ram_we_n)                                we_low_cnt <= '0;
      else if (we_low_cnt != WEC_W'(WR_PULSE_C))   we_low_cnt <= we_low_cnt + 1'b1;
      if (!ram_oe_n)                               since_oe <= '0;
      else if (since_oe != TRC_W'(TURN_C))         since_oe <= since_oe + 1'b1;
    end
  end

  assert_no_drive_under_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ram_dq_oe |-> ram_oe_n);

  assert_we_qualified_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_ce_n && ram_oe_n));

  assert_pins_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_we_n || $past(!ram_we_n)) |-> ($stable(ram_addr) && $stable(ram_dq_out) && ram_dq_oe));

  assert_we_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_low_cnt >= WEC_W'(WR_PULSE_C)));

  assert_bus_turn_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_dq_oe) |-> (since_oe >= TRC_W'(TURN_C)));

endmodule

// File: rtl/bytelane_sram_ctrl.sv
`timescale 1ns/1ps
module bytelane_sram_ctrl
  import bls_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int CLK_PS     = 10000,
  parameter int SLOW_GRADE = 0
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  input  logic [DATA_W/8-1:0]      req_mask,
  output logic                     rsp_valid,
  output logic [DATA_W-1:0]        rsp_rdata,
  output logic [ADDR_W-1:0]        ram_addr,
  output logic                     ram_ce_n,
  output logic                     ram_we_n,
  output logic                     ram_oe_n,
  output logic [DATA_W/8-1:0]      ram_be_n,
  output logic [DATA_W-1:0]        ram_dq_out,
  output logic                     ram_dq_oe,
  input  logic [DATA_W-1:0]        ram_dq_in
);

  localparam int LANES = DATA_W / 8;

  // nanosecond minimums per grade
  localparam int T_AA  = SLOW_GRADE ? 70 : 55;
  localparam int T_DOE = SLOW_GRADE ? 35 : 25;
  localparam int T_WC  = SLOW_GRADE ? 70 : 55;
  localparam int T_PWE = SLOW_GRADE ? 50 : 40;
  localparam int T_SCE = SLOW_GRADE ? 60 : 40;
  localparam int T_SD  = SLOW_GRADE ? 30 : 25;
  localparam int T_REL = SLOW_GRADE ? 25 : 20;

  localparam int RD_WAIT_C  = imax(1, imax(cyc_ceil(T_AA, CLK_PS) - 1, cyc_ceil(T_DOE, CLK_PS)));
  localparam int WR_PULSE_C = imax(1, imax(cyc_ceil(T_PWE, CLK_PS),
                                           cyc_ceil(imax(T_SCE, T_SD), CLK_PS) - 1));
  localparam int WR_REC_C   = imax(1, cyc_ceil(T_WC, CLK_PS) - 1 - WR_PULSE_C);
  localparam int TURN_C     = imax(1, cyc_ceil(T_REL, CLK_PS));
  localparam int MAX_C      = imax(imax(RD_WAIT_C, WR_PULSE_C), imax(WR_REC_C, TURN_C));
  localparam int CNT_W      = imax(1, $clog2(MAX_C + 1));

  bls_state_e          state;
  logic                accept, sample;
  logic [ADDR_W-1:0]   h_addr;
  logic [DATA_W-1:0]   h_wdata;
  logic [LANES-1:0]    h_mask;

  bls_fsm #(
    .RD_WAIT_C (RD_WAIT_C),
    .WR_PULSE_C(WR_PULSE_C),
    .WR_REC_C  (WR_REC_C),
    .TURN_C    (TURN_C),
    .CNT_W     (CNT_W)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_ready(req_ready),
    .accept   (accept),
    .sample   (sample),
    .rsp_valid(rsp_valid),
    .state    (state)
  );

  bls_hold #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W),
    .LANES (LANES)
  ) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .sample   (sample),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .in_mask  (req_mask),
    .ram_dq_in(ram_dq_in),
    .h_addr   (h_addr),
    .h_wdata  (h_wdata),
    .h_mask   (h_mask),
    .rdata    (rsp_rdata)
  );

  bls_pins #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LANES     (LANES),
    .WR_PULSE_C(WR_PULSE_C),
    .TURN_C    (TURN_C)
  ) u_pins (
    .clk       (clk),
    .rst_n     (rst_n),
    .state     (state),
    .h_addr    (h_addr),
    .h_wdata   (h_wdata),
    .h_mask    (h_mask),
    .ram_addr  (ram_addr),
    .ram_ce_n  (ram_ce_n),
    .ram_we_n  (ram_we_n),
    .ram_oe_n  (ram_oe_n),
    .ram_be_n  (ram_be_n),
    .ram_dq_out(ram_dq_out),
    .ram_dq_oe (ram_dq_oe)
  );

  assert_ready_only_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_ce_n && !ram_dq_oe));

  assert_ready_drops_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_read_strobes_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_oe_n |-> (ram_we_n && !ram_ce_n));

  assert_empty_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_mask == '0) |=> (ram_be_n == '1));

endmodule

// File: tb/bytelane_sram_ctrl_tb_top.sv
`timescale 1ns/1ps
module bytelane_sram_ctrl_tb_top;

  localparam int CLK_PS = 10000;

  function automatic int cc(input int ns);
    return (ns * 1000 + CLK_PS - 1) / CLK_PS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // expected phase lengths from the requirement formulas (fast grade)
  localparam int EXP_W      = mx(cc(55) - 1, cc(25));
  localparam int EXP_P      = mx(cc(40), cc(40) - 1);
  localparam int EXP_Q      = mx(1, cc(55) - 1 - EXP_P);
  localparam int EXP_T      = mx(1, cc(20));
  localparam int EXP_RD_LAT = EXP_W + 2;
  localparam int EXP_WR_LAT = EXP_P + EXP_Q + 1;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_mask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] ram_addr;
  logic        ram_ce_n, ram_we_n, ram_oe_n, ram_dq_oe;
  logic [1:0]  ram_be_n;
  logic [15:0] ram_dq_out, ram_dq_in;

  always #5 clk = ~clk;

  bytelane_sram_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n),
    .ram_oe_n(ram_oe_n), .ram_be_n(ram_be_n), .ram_dq_out(ram_dq_out),
    .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  int n_checks = 0;
  int n_fail   = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [15:0] mem [0:1023];
  logic        ram_drive, wact, prev_wact;
  int          oe_cnt, rel_cnt, ds_cnt, ds_end;
  int          contention, setup_bad, hold_bad;
  logic [17:0] pend_addr;
  logic [15:0] pend_data, last_dq;
  logic [1:0]  pend_be;

  assign ram_drive = !ram_ce_n && !ram_oe_n && ram_we_n && (ram_be_n != 2'b11);
  assign wact      = !ram_ce_n && !ram_we_n && (ram_be_n != 2'b11);

  always_comb begin
    for (int l = 0; l < 2; l++) begin
      if (ram_drive && !ram_be_n[l] && oe_cnt >= 2)
        ram_dq_in[l*8 +: 8] = mem[ram_addr[9:0]][l*8 +: 8];
      else
        ram_dq_in[l*8 +: 8] = 8'hA5;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 1024; i++) mem[i] = 16'h0000;
      oe_cnt = 0; rel_cnt = 0; ds_cnt = 0; ds_end = 0; prev_wact = 1'b0;
      contention = 0; setup_bad = 0; hold_bad = 0; last_dq = '0;
    end else begin
      if (ram_dq_oe && (ram_drive || rel_cnt > 0)) contention++;
      rel_cnt = ram_drive ? 2 : (rel_cnt > 0 ? rel_cnt - 1 : 0);
      oe_cnt  = ram_oe_n ? 0 : oe_cnt + 1;
      if (prev_wact && !wact) begin
        for (int l = 0; l < 2; l++)
          if (!pend_be[l]) mem[pend_addr[9:0]][l*8 +: 8] = pend_data[l*8 +: 8];
        if (ds_end < 2) setup_bad++;
        if (!ram_dq_oe || ram_dq_out != pend_data || ram_addr != pend_addr) hold_bad++;
      end
      if (wact) begin
        pend_addr = ram_addr; pend_data = ram_dq_out; pend_be = ram_be_n; ds_end = ds_cnt;
      end
      ds_cnt    = (ram_dq_oe && ram_dq_out == last_dq) ? ds_cnt + 1 : 0;
      last_dq   = ram_dq_out;
      prev_wact = wact;
    end
  end

  // ---------------- pin-level monitors ----------------
  int          we_run, we_min, we_addr_bad, we_unqual, oe_clash;
  logic [17:0] prev_addr, first_addr;
  logic        prev_ce_n;

  always @(negedge clk) begin
    if (!rst_n) begin
      we_run = 0; we_min = 1000; we_addr_bad = 0; we_unqual = 0; oe_clash = 0;
    end else begin
      if (ram_dq_oe && !ram_oe_n) oe_clash++;
      if (!ram_we_n && ram_ce_n) we_unqual++;
      if (!ram_we_n) begin
        if (we_run == 0) begin
          first_addr = ram_addr;
          if (prev_addr != ram_addr || prev_ce_n) we_addr_bad++;
        end else if (ram_addr != first_addr) we_addr_bad++;
        we_run++;
      end else if (we_run > 0) begin
        if (we_run < we_min) we_min = we_run;
        if (ram_addr != first_addr) we_addr_bad++;
        we_run = 0;
      end
    end
    prev_addr = ram_addr;
    prev_ce_n = ram_ce_n;
  end

  // ---------------- host tasks ----------------
  int busy_ready;

  task automatic host_req(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] m, output logic [15:0] rd, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (req_ready) busy_ready++;
    lat = 1;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
      if (req_ready && !rsp_valid) busy_ready++;
    end
    rd = rsp_rdata;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_mask = '0;
    repeat (3) @(negedge clk);
    check(ram_ce_n && ram_we_n && ram_oe_n && ram_be_n == 2'b11, "R9 strobes idle",
          {ram_ce_n, ram_we_n, ram_oe_n, ram_be_n}, 5'h1F);
    check(!ram_dq_oe && !rsp_valid, "R9 bus and done low", {ram_dq_oe, rsp_valid}, 0);
    check(req_ready, "R9 ready in reset", req_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_full_word;
    logic [15:0] rd; int lat;
    host_req(1'b1, 18'h00012, 16'hBEEF, 2'b11, rd, lat);
    check(lat == EXP_WR_LAT, "R5 write latency", lat, EXP_WR_LAT);
    host_req(1'b0, 18'h00012, 16'h0000, 2'b11, rd, lat);
    check(lat == EXP_RD_LAT, "R5 read latency", lat, EXP_RD_LAT);
    check(rd == 16'hBEEF, "R4 full-word read", rd, 16'hBEEF);
  endtask

  task automatic t_partial;
    logic [15:0] rd; int lat;
    host_req(1'b1, 18'h00040, 16'h3311, 2'b01, rd, lat);
    host_req(1'b1, 18'h00040, 16'h22AA, 2'b10, rd, lat);
    host_req(1'b0, 18'h00040, 16'h0000, 2'b11, rd, lat);
    check(rd == 16'h2211, "R2 merged partial writes", rd, 16'h2211);
    host_req(1'b0, 18'h00040, 16'h0000, 2'b01, rd, lat);
    check(rd == 16'h0011, "R4 low-lane read, high zero", rd, 16'h0011);
    host_req(1'b0, 18'h00040, 16'h0000, 2'b10, rd, lat);
    check(rd == 16'h2200, "R4 high-lane read, low zero", rd, 16'h2200);
  endtask

  task automatic t_empty_mask;
    logic [15:0] rd; int lat;
    host_req(1'b1, 18'h00040, 16'hFFFF, 2'b00, rd, lat);
    host_req(1'b0, 18'h00040, 16'h0000, 2'b11, rd, lat);
    check(rd == 16'h2211, "R8 empty-mask write ignored", rd, 16'h2211);
    host_req(1'b0, 18'h00040, 16'h0000, 2'b00, rd, lat);
    check(rd == 16'h0000, "R8 empty-mask read zero", rd, 16'h0000);
  endtask

  task automatic t_handshake;
    logic [15:0] rd; int lat; int gap;
    busy_ready = 0;
    host_req(1'b0, 18'h00012, 16'h0000, 2'b11, rd, lat);
    gap = 0;
    while (!req_ready) begin @(negedge clk); gap++; end
    check(gap == EXP_T + 1, "R7 ready after read", gap, EXP_T + 1);
    host_req(1'b1, 18'h00013, 16'h5A3C, 2'b11, rd, lat);
    gap = 0;
    while (!req_ready) begin @(negedge clk); gap++; end
    check(gap == EXP_T + 1, "R7 ready after write", gap, EXP_T + 1);
    host_req(1'b0, 18'h00013, 16'h0000, 2'b11, rd, lat);
    check(rd == 16'h5A3C, "R4 back-to-back read", rd, 16'h5A3C);
    check(busy_ready == 0, "R1 ready low while busy", busy_ready, 0);
  endtask

  task automatic t_monitors;
    check(contention == 0, "R6 bus contention", contention, 0);
    check(oe_clash == 0, "R6 drive with output enable", oe_clash, 0);
    check(setup_bad == 0 && hold_bad == 0, "R3 data setup/hold", setup_bad + hold_bad, 0);
    check(we_min >= EXP_P, "R3 write pulse width", we_min, EXP_P);
    check(we_addr_bad == 0, "R3 address around write", we_addr_bad, 0);
    check(we_unqual == 0, "R2 write without chip enable", we_unqual, 0);
  endtask

  bit done = 1'b0;

  initial begin
    t_reset();
    t_full_word();
    t_partial();
    t_empty_mask();
    t_handshake();
    t_monitors();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule